// File: doc/BRIEF.md
# Reverse-Channel Byte Transmitter

This block sits at the peripheral end of a bidirectional parallel port. It sends one byte to the host in the reverse direction. A local requester presents a byte and a flag that marks it as payload data or as a channel-address command, and pulses a send request. The block first samples the host's direction line. If the host has not asked for reverse traffic, the block does not wait: it reports a skip straight away, so the requester can do other work.

When the host has granted reverse direction, the block runs a full interlocked handshake. It acknowledges the direction request and then takes the shared data bus. It marks the cycle type and lowers its strobe to show that the data is valid. It waits for the host to acknowledge, raises the strobe so the host can latch the byte, and waits for the host to withdraw its acknowledge. It then releases the bus and returns every line to its idle level. If the host revokes reverse direction while the block is waiting on it, the block abandons the byte and restores the idle levels. The two host inputs are asynchronous and pass through a two-flop synchronizer.

Top module: `revchan_tx`

## Requirements
- R1: During and after reset, with no request made, dir_grant_n=1, data_strobe=1, cycle_is_data=0, bus_oe=0, and no pulse is set on xfer_done, xfer_skip or xfer_abort.
- R2: A send_req taken while the synchronized host_dir_n is high leaves all lines idle and sets xfer_skip for one cycle, in the cycle after the request edge.
- R3: A send_req taken while the synchronized host_dir_n is low drives dir_grant_n low one cycle after the request edge with bus_oe still 0. One cycle later, bus_oe is 1 and bus_dout carries the latched byte.
- R4: While the bus is driven, cycle_is_data is 1 for a data byte (tx_is_cmd=0) and 0 for a command byte (tx_is_cmd=1).
- R5: One cycle after the bus is first driven, data_strobe goes low. It stays low until host_latch_ack is seen high, and then returns high.
- R6: After host_latch_ack is seen low again, bus_oe, dir_grant_n and cycle_is_data go to their idle levels and xfer_done is set for one cycle, in the same cycle as that change.
- R7: If host_dir_n is seen high while the block waits for host_latch_ack to rise or fall, the transfer ends: all lines return to idle and xfer_abort is set for one cycle.
- R8: Each host input reaches the state logic through two flops. A change on an input therefore becomes visible on the outputs in the third clock edge after it, and not earlier.
- R9: A send_req that arrives while a transfer is in progress is ignored: the byte and cycle type on the bus stay unchanged and no extra event follows.
- R10: At most one of xfer_done, xfer_skip and xfer_abort is set in any cycle. Each pulse lasts one cycle, and there is exactly one pulse per accepted request.
- R11: bus_oe is never 1 while dir_grant_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | One-cycle request to send a byte |
| tx_byte | input | DATA_W | Byte to send |
| tx_is_cmd | input | 1 | 1 = channel-address command, 0 = data |
| host_dir_n | input | 1 | Host direction line (asynchronous), low requests reverse traffic |
| host_latch_ack | input | 1 | Host acknowledge line (asynchronous) |
| dir_grant_n | output | 1 | Low while the reverse request is acknowledged |
| cycle_is_data | output | 1 | Cycle type: 1 data, 0 command |
| data_strobe | output | 1 | Low marks valid data; the rising edge is the latch point |
| bus_oe | output | 1 | Drive enable of the shared data bus |
| bus_dout | output | DATA_W | Value driven onto the data bus |
| xfer_done | output | 1 | One-cycle pulse: byte delivered |
| xfer_skip | output | 1 | One-cycle pulse: request dropped, host not in reverse mode |
| xfer_abort | output | 1 | One-cycle pulse: transfer abandoned by the host |

## Verification
The assertions assume that the host follows the interlock. It raises its acknowledge only while the strobe is low and drops it only after the strobe has risen again, and it changes the direction line only when the block is idle or waiting on the host. The stimulus plays this host role from the port levels it observes. It always waits at least three clocks after lowering the direction line before it requests a send, so the synchronized value has settled. It revokes direction only inside the two wait phases.

// File: rtl/revtx_pkg.sv
package revtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GRANT,
        ST_DRIVE,
        ST_WAIT_HI,
        ST_WAIT_LO
    } revtx_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_DONE,
        EV_SKIP,
        EV_ABORT
    } revtx_event_e;

    typedef struct packed {
        logic grant_n;
        logic is_data;
        logic strobe;
        logic drive;
    } revtx_lines_t;

    localparam revtx_lines_t LINES_IDLE = '{grant_n: 1'b1, is_data: 1'b0, strobe: 1'b1, drive: 1'b0};

    function automatic revtx_lines_t lines_for(revtx_state_e st, logic is_cmd);
        revtx_lines_t l;
        l = LINES_IDLE;
        case (st)
            ST_GRANT:   l.grant_n = 1'b0;
            ST_DRIVE:   l = '{grant_n: 1'b0, is_data: ~is_cmd, strobe: 1'b1, drive: 1'b1};
            ST_WAIT_HI: l = '{grant_n: 1'b0, is_data: ~is_cmd, strobe: 1'b0, drive: 1'b1};
            ST_WAIT_LO: l = '{grant_n: 1'b0, is_data: ~is_cmd, strobe: 1'b1, drive: 1'b1};
            default:    l = LINES_IDLE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/revtx_sync.sv
module revtx_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/revtx_ctrl.sv
module revtx_ctrl
    import revtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_req,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_is_cmd,
    input  logic              dir_n_s,
    input  logic              ack_s,
    output revtx_lines_t      lines,
    output logic [DATA_W-1:0] dout,
    output revtx_event_e      evt
);
    revtx_state_e      state_q;
    logic [DATA_W-1:0] byte_q;
    logic              cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt     <= EV_NONE;
            byte_q  <= '0;
            cmd_q   <= 1'b0;
        end else begin
            evt <= EV_NONE;
            case (state_q)
                ST_IDLE: begin
                    if (send_req) begin
                        if (dir_n_s) begin
                            evt <= EV_SKIP;
                        end else begin
                            byte_q  <= tx_byte;
                            cmd_q   <= tx_is_cmd;
                            state_q <= ST_GRANT;
                        end
                    end
                end
                ST_GRANT: state_q <= ST_DRIVE;
                ST_DRIVE: state_q <= ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (dir_n_s) begin
                        state_q <= ST_IDLE;
                        evt     <= EV_ABORT;
                    end else if (ack_s) begin
                        state_q <= ST_WAIT_LO;
                    end
                end
                ST_WAIT_LO: begin
                    if (dir_n_s) begin
                        state_q <= ST_IDLE;
                        evt     <= EV_ABORT;
                    end else if (!ack_s) begin
                        state_q <= ST_IDLE;
                        evt     <= EV_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign lines = lines_for(state_q, cmd_q);
    assign dout  = byte_q;
endmodule

// File: rtl/revchan_tx.sv
module revchan_tx
    import revtx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_req,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_is_cmd,
    input  logic              host_dir_n,
    input  logic              host_latch_ack,
    output logic              dir_grant_n,
    output logic              cycle_is_data,
    output logic              data_strobe,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic              xfer_done,
    output logic              xfer_skip,
    output logic              xfer_abort
);
    localparam int HOST_W = 2;

    logic [HOST_W-1:0] host_raw, host_s;
    revtx_lines_t      lines;
    revtx_event_e      evt;

    assign host_raw = {host_latch_ack, host_dir_n};

    revtx_sync #(
        .WIDTH  (HOST_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (host_raw),
        .dout(host_s)
    );

    revtx_ctrl #(
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .send_req (send_req),
        .tx_byte  (tx_byte),
        .tx_is_cmd(tx_is_cmd),
        .dir_n_s  (host_s[0]),
        .ack_s    (host_s[1]),
        .lines    (lines),
        .dout     (bus_dout),
        .evt      (evt)
    );

    assign dir_grant_n   = lines.grant_n;
    assign cycle_is_data = lines.is_data;
    assign data_strobe   = lines.strobe;
    assign bus_oe        = lines.drive;
    assign xfer_done     = (evt == EV_DONE);
    assign xfer_skip     = (evt == EV_SKIP);
    assign xfer_abort    = (evt == EV_ABORT);
endmodule

// File: rtl/revchan_tx_chk.sv
module revchan_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dir_grant_n,
    input logic              cycle_is_data,
    input logic              data_strobe,
    input logic              bus_oe,
    input logic [DATA_W-1:0] bus_dout,
    input logic              xfer_done,
    input logic              xfer_skip,
    input logic              xfer_abort
);
    p_oe_needs_grant_r11: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !dir_grant_n);

    p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
        $countones({xfer_done, xfer_skip, xfer_abort}) <= 1);

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        xfer_skip |-> (dir_grant_n && !bus_oe && data_strobe));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (dir_grant_n && !bus_oe && !cycle_is_data && data_strobe));

    p_abort_idle_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |-> (dir_grant_n && !bus_oe && !cycle_is_data && data_strobe));

    p_strobe_low_driven_r5: assert property (@(posedge clk) disable iff (rst)
        !data_strobe |-> bus_oe);

    p_bus_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> ($stable(cycle_is_data) && $stable(bus_dout)));

    p_grant_before_drive_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(!dir_grant_n));
endmodule

bind revchan_tx revchan_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/revchan_tx_test.sv
module revchan_tx_test;
    localparam int DW = 8;
    localparam int EV_DONE = 1, EV_SKIP = 2, EV_ABORT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          send_req = 1'b0;
    logic [DW-1:0] tx_byte = '0;
    logic          tx_is_cmd = 1'b0;
    logic          host_dir_n = 1'b1;
    logic          host_latch_ack = 1'b0;
    logic          dir_grant_n, cycle_is_data, data_strobe, bus_oe;
    logic [DW-1:0] bus_dout;
    logic          xfer_done, xfer_skip, xfer_abort;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    revchan_tx #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .send_req(send_req), .tx_byte(tx_byte),
        .tx_is_cmd(tx_is_cmd), .host_dir_n(host_dir_n),
        .host_latch_ack(host_latch_ack), .dir_grant_n(dir_grant_n),
        .cycle_is_data(cycle_is_data), .data_strobe(data_strobe),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .xfer_done(xfer_done),
        .xfer_skip(xfer_skip), .xfer_abort(xfer_abort)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int idle_code();
        return {dir_grant_n, cycle_is_data, data_strobe, bus_oe};
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: pops expected events as pulses appear
    always @(negedge clk) begin
        if (!rst) begin
            int n;
            int got;
            n = int'(xfer_done) + int'(xfer_skip) + int'(xfer_abort);
            if (n > 1) check(1'b0, "R10", n, 1);
            if (n != 0) begin
                got = xfer_done ? EV_DONE : (xfer_skip ? EV_SKIP : EV_ABORT);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", got, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(got == e, "R10", got, e);
                end
            end
        end
    end

    // abort_at: 0 none, 1 during rise wait, 2 during fall wait
    task automatic do_send(input logic [DW-1:0] b, input logic c, input int abort_at);
        send_req = 1'b1; tx_byte = b; tx_is_cmd = c;
        @(negedge clk);
        send_req = 1'b0;
        check(dir_grant_n == 1'b0, "R3", dir_grant_n, 0);
        check(bus_oe == 1'b0, "R3", bus_oe, 0);
        @(negedge clk);
        check(bus_oe == 1'b1 && bus_dout == b, "R3", {bus_oe, bus_dout}, {1'b1, b});
        check(cycle_is_data == !c, "R4", cycle_is_data, !c);
        check(data_strobe == 1'b1, "R5", data_strobe, 1);
        @(negedge clk);
        check(data_strobe == 1'b0, "R5", data_strobe, 0);
        // request during transfer must be ignored (R9)
        send_req = 1'b1; tx_byte = ~b; tx_is_cmd = !c;
        @(negedge clk);
        send_req = 1'b0;
        check(bus_dout == b && cycle_is_data == !c && data_strobe == 1'b0, "R9",
              {bus_dout, cycle_is_data}, {b, !c});
        if (abort_at == 1) begin
            exp_q.push_back(EV_ABORT);
            host_dir_n = 1'b1;
            repeat (3) @(negedge clk);
            check(idle_code() == 4'b1010, "R7", idle_code(), 4'b1010);
            host_dir_n = 1'b0;
            repeat (4) @(negedge clk);
            return;
        end
        host_latch_ack = 1'b1;
        repeat (2) @(negedge clk);
        check(data_strobe == 1'b0, "R8", data_strobe, 0);
        @(negedge clk);
        check(data_strobe == 1'b1 && bus_oe == 1'b1, "R5", {data_strobe, bus_oe}, 2'b11);
        if (abort_at == 2) begin
            exp_q.push_back(EV_ABORT);
            host_dir_n = 1'b1;
            repeat (3) @(negedge clk);
            check(idle_code() == 4'b1010, "R7", idle_code(), 4'b1010);
            host_latch_ack = 1'b0;
            host_dir_n = 1'b0;
            repeat (4) @(negedge clk);
            return;
        end
        exp_q.push_back(EV_DONE);
        host_latch_ack = 1'b0;
        repeat (2) @(negedge clk);
        check(bus_oe == 1'b1, "R8", bus_oe, 1);
        @(negedge clk);
        check(idle_code() == 4'b1010, "R6", idle_code(), 4'b1010);
        check(xfer_done == 1'b1, "R6", xfer_done, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(idle_code() == 4'b1010, "R1", idle_code(), 4'b1010);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(idle_code() == 4'b1010 && !xfer_done && !xfer_skip && !xfer_abort,
              "R1", idle_code(), 4'b1010);

        // skip: host still forward
        exp_q.push_back(EV_SKIP);
        send_req = 1'b1; tx_byte = 8'h5A;
        @(negedge clk);
        send_req = 1'b0;
        check(xfer_skip == 1'b1, "R2", xfer_skip, 1);
        check(idle_code() == 4'b1010, "R2", idle_code(), 4'b1010);
        @(negedge clk);
        check(xfer_skip == 1'b0, "R10", xfer_skip, 0);

        host_dir_n = 1'b0;
        repeat (4) @(negedge clk);
        do_send(8'hA5, 1'b0, 0);
        do_send(8'h3C, 1'b1, 0);
        do_send(8'h00, 1'b0, 0);
        do_send(8'hFF, 1'b1, 0);
        do_send(8'h81, 1'b0, 1);
        do_send(8'h7E, 1'b1, 2);
        do_send(8'h42, 1'b0, 0);

        // skip again after forward direction is restored
        host_dir_n = 1'b1;
        repeat (4) @(negedge clk);
        exp_q.push_back(EV_SKIP);
        send_req = 1'b1; tx_byte = 8'h11;
        @(negedge clk);
        send_req = 1'b0;
        check(xfer_skip == 1'b1 && bus_oe == 1'b0, "R2", {xfer_skip, bus_oe}, 2'b10);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule